// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves a data word between two ports, A and B, through two separate storage paths: one carries A toward B, the other carries B toward A. Each path has three active-low controls of its own. The path enable must be low for the path to accept or present data. The capture strobe, together with the path enable, picks between following the source and holding a frozen copy. The drive enable decides whether the opposite port is driven. Data is never inverted.

The block is synchronous. Every control and data input is sampled on the rising edge of `clk`, and a rising control edge is found by comparing the sample with the one taken the cycle before. Each port appears as a plain input bus, a data output bus and a per-bit drive-enable bus, so a pad ring or tri-state wrapper at the chip level can build the real bidirectional pins. A status output reports when both paths drive their destinations in the same cycle. Each output reflects the inputs sampled at the previous rising edge, a latency of one cycle.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both stored words to 0x00, forces both drive-enable buses and the contention flag low, and leaves both strobes' edge history at the inactive (high) level. In the first cycle after reset, a high strobe therefore counts as no edge.
- R2: While a path's enable and strobe are both sampled low, the path is transparent. One cycle after each sample, its data output equals the sampled source word.
- R3: A strobe sample that is high, when the previous sample was low and the path enable is sampled low, captures the source word of that sample. Later source changes do not reach the output.
- R4: A path-enable sample that is high, when the previous sample was low, captures the source word of that sample, in the same way as a strobe rising edge.
- R5: With the path enable low and the strobe high in both the current and the previous sample, the stored word does not change.
- R6: Every bit of a destination's drive-enable bus is 1 one cycle after that path's enable and drive enable are both sampled low, and 0 one cycle after either is sampled high, whatever the strobe does.
- R7: A word captured while the drive enable is high is presented unchanged on the data output when the drive is later enabled.
- R8: Each output bit equals the source bit at the same position (bit n to bit n), with no inversion.
- R9: The two paths are independent: controls and data of one path never change the other path's stored word or drive enable.
- R10: When both paths drive in the same cycle, both drive-enable buses are still all ones and `contention_o` is 1. Otherwise `contention_o` is 0.
- R11: While the path enable is sampled high in both the current and the previous cycle, a rising strobe does not capture. The stored word is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ab_en_n | input | 1 | A-to-B path enable, active low |
| ab_le_n | input | 1 | A-to-B capture strobe, active low (rising edge captures) |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ba_en_n | input | 1 | B-to-A path enable, active low |
| ba_le_n | input | 1 | B-to-A capture strobe, active low (rising edge captures) |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| a_in | input | WIDTH | Word read from port A (source of the A-to-B path) |
| a_out | output | WIDTH | Word to drive onto port A (B-to-A stored value) |
| a_drive | output | WIDTH | Per-bit drive enable for port A, active high |
| b_in | input | WIDTH | Word read from port B (source of the B-to-A path) |
| b_out | output | WIDTH | Word to drive onto port B (A-to-B stored value) |
| b_drive | output | WIDTH | Per-bit drive enable for port B, active high |
| contention_o | output | 1 | High while both ports are driven at once |

## Verification
The assertions assume that every control and data input is synchronous to `clk` and settled at each rising edge, and that `rst` is high at the first edge so the edge history starts from a known level. The properties compare each output with the samples taken one edge earlier. The stimulus changes inputs only on the falling clock edge and holds reset over the first edges, so every sample is clean. The vector sequence is ordered so that each strobe and enable rising edge is preceded by an explicit low sample, which lets the capture, hold and ignored-strobe cases each be reached on purpose.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Sampled controls of one direction (all active low)
    typedef struct packed {
        logic en_n;
        logic le_n;
        logic oe_n;
    } xcvr_ctl_t;

    // What the storage register of a direction does on the next edge
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_PASS    = 2'd1,
        ACT_CAPTURE = 2'd2
    } xcvr_act_e;

    localparam int unsigned NUM_DIRS = 2;
    localparam int unsigned DIR_AB   = 0;
    localparam int unsigned DIR_BA   = 1;

endpackage

// File: rtl/xcvr_strobe.sv
module xcvr_strobe
    import xcvr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_n_i,
    input  logic      le_n_i,
    output xcvr_act_e act_o
);

    typedef struct packed {
        logic en_n;
        logic le_n;
    } hist_t;

    hist_t     st_d, st_q;
    logic      en_rise, le_rise;
    xcvr_act_e act;

    always_comb begin
        st_d.en_n = en_n_i;
        st_d.le_n = le_n_i;
        en_rise   = en_n_i & ~st_q.en_n;
        le_rise   = le_n_i & ~st_q.le_n & ~en_n_i;
        if (!en_n_i && !le_n_i) begin
            act = ACT_PASS;
        end else if (en_rise || le_rise) begin
            act = ACT_CAPTURE;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{en_n: 1'b1, le_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = act;

    // R11: a strobe edge with the path enable steadily high never captures
    a_r11_strobe_ignored_when_off: assert property (@(posedge clk) disable iff (rst)
        (en_n_i && st_q.en_n) |-> (act_o == ACT_HOLD));

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  xcvr_ctl_t        ctl_i,
    input  xcvr_act_e        act_i,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] dst_o,
    output logic [WIDTH-1:0] drive_o
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             drive;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act_i != ACT_HOLD) begin
            st_d.data = src_i;
        end
        st_d.drive = ~ctl_i.en_n & ~ctl_i.oe_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_o   = st_q.data;
    assign drive_o = {WIDTH{st_q.drive}};

    // R2: transparent path follows the source one cycle later
    a_r2_transparent: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.en_n && !ctl_i.le_n) |=> (dst_o == $past(src_i)));

    // R5: enable low, strobe steadily high: word is kept
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_HOLD) |=> $stable(dst_o));

    // R6: either control high disables the destination
    a_r6_disabled: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.en_n || ctl_i.oe_n) |=> (drive_o == '0));

    // R6: both controls low drive every bit
    a_r6_enabled: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.en_n && !ctl_i.oe_n) |=> (drive_o == {WIDTH{1'b1}}));

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ab_en_n,
    input  logic             ab_le_n,
    input  logic             ab_oe_n,
    input  logic             ba_en_n,
    input  logic             ba_le_n,
    input  logic             ba_oe_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_drive,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_drive,
    output logic             contention_o
);

    xcvr_ctl_t        ctl   [NUM_DIRS];
    logic [WIDTH-1:0] src   [NUM_DIRS];
    logic [WIDTH-1:0] dst   [NUM_DIRS];
    logic [WIDTH-1:0] drv   [NUM_DIRS];
    xcvr_act_e        act   [NUM_DIRS];

    assign ctl[DIR_AB] = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
    assign ctl[DIR_BA] = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
    assign src[DIR_AB] = a_in;
    assign src[DIR_BA] = b_in;

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        xcvr_strobe i_strobe (
            .clk    (clk),
            .rst    (rst),
            .en_n_i (ctl[d].en_n),
            .le_n_i (ctl[d].le_n),
            .act_o  (act[d])
        );

        xcvr_store #(.WIDTH(WIDTH)) i_store (
            .clk     (clk),
            .rst     (rst),
            .ctl_i   (ctl[d]),
            .act_i   (act[d]),
            .src_i   (src[d]),
            .dst_o   (dst[d]),
            .drive_o (drv[d])
        );
    end

    assign b_out        = dst[DIR_AB];
    assign b_drive      = drv[DIR_AB];
    assign a_out        = dst[DIR_BA];
    assign a_drive      = drv[DIR_BA];
    assign contention_o = drv[DIR_AB][0] & drv[DIR_BA][0];

    // R1: reset clears words, drives and contention
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (a_out == '0 && b_out == '0 && a_drive == '0 && b_drive == '0 && !contention_o));

    // R4: path-enable rising edge captures the port-A word into the A-to-B path
    a_r4_enable_rise_capture: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_n ##1 ab_en_n) |=> (b_out == $past(a_in)));

    // R3: strobe rising edge with enable low captures the port-B word into the B-to-A path
    a_r3_strobe_rise_capture: assert property (@(posedge clk) disable iff (rst)
        ((!ba_le_n && !ba_en_n) ##1 (ba_le_n && !ba_en_n)) |=> (a_out == $past(b_in)));

    // R10: simultaneous drive keeps both enables and raises the flag
    a_r10_contention: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_n && !ab_oe_n && !ba_en_n && !ba_oe_n) |=>
            (contention_o && (&a_drive) && (&b_drive)));

endmodule

// File: tb/test_bidir_latch_xcvr.sv
module test_bidir_latch_xcvr;

    localparam int unsigned W    = 8;
    localparam int unsigned NVEC = 13;

    // ctl fields are {en_n, le_n, oe_n}
    typedef struct packed {
        logic [2:0]   ab;
        logic [2:0]   ba;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] exp_b;
        logic         exp_bd;
        logic [W-1:0] exp_a;
        logic         exp_ad;
        logic         exp_c;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'b000, 3'b111, 8'hA5, 8'h3C, 8'hA5, 1'b1, 8'h00, 1'b0, 1'b0},
        '{3'b000, 3'b111, 8'h5A, 8'h3C, 8'h5A, 1'b1, 8'h00, 1'b0, 1'b0},
        '{3'b010, 3'b111, 8'hC3, 8'h3C, 8'hC3, 1'b1, 8'h00, 1'b0, 1'b0},
        '{3'b010, 3'b111, 8'hFF, 8'h3C, 8'hC3, 1'b1, 8'h00, 1'b0, 1'b0},
        '{3'b011, 3'b111, 8'h11, 8'h3C, 8'hC3, 1'b0, 8'h00, 1'b0, 1'b0},
        '{3'b110, 3'b111, 8'h22, 8'h3C, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0},
        '{3'b010, 3'b111, 8'h33, 8'h3C, 8'h22, 1'b1, 8'h00, 1'b0, 1'b0},
        '{3'b101, 3'b111, 8'h44, 8'h3C, 8'h44, 1'b0, 8'h00, 1'b0, 1'b0},
        '{3'b111, 3'b111, 8'h55, 8'h3C, 8'h44, 1'b0, 8'h00, 1'b0, 1'b0},
        '{3'b010, 3'b111, 8'h66, 8'h3C, 8'h44, 1'b1, 8'h00, 1'b0, 1'b0},
        '{3'b010, 3'b000, 8'h66, 8'h96, 8'h44, 1'b1, 8'h96, 1'b1, 1'b1},
        '{3'b001, 3'b010, 8'h77, 8'h69, 8'h77, 1'b0, 8'h69, 1'b1, 1'b0},
        '{3'b000, 3'b110, 8'h81, 8'h00, 8'h81, 1'b1, 8'h00, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
    logic         ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_drive, b_out, b_drive;
    logic         contention_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bidir_latch_xcvr #(.WIDTH(W)) i_bidir_latch_xcvr (
        .clk          (clk),
        .rst          (rst),
        .ab_en_n      (ab_en_n),
        .ab_le_n      (ab_le_n),
        .ab_oe_n      (ab_oe_n),
        .ba_en_n      (ba_en_n),
        .ba_le_n      (ba_le_n),
        .ba_oe_n      (ba_oe_n),
        .a_in         (a_in),
        .a_out        (a_out),
        .a_drive      (a_drive),
        .b_in         (b_in),
        .b_out        (b_out),
        .b_drive      (b_drive),
        .contention_o (contention_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [W-1:0] eb, input logic ebd,
                             input logic [W-1:0] ea, input logic ead, input logic ec);
        check(tag, "b_out",      b_out,   eb);
        check(tag, "b_drive",    b_drive, {W{ebd}});
        check(tag, "a_out",      a_out,   ea);
        check(tag, "a_drive",    a_drive, {W{ead}});
        check(tag, "contention", {{(W-1){1'b0}}, contention_o}, {{(W-1){1'b0}}, ec});
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R2";
            1:       return "R8";
            2:       return "R3";
            3:       return "R5";
            4:       return "R6";
            5:       return "R4";
            6:       return "R7";
            7:       return "R4";
            8:       return "R11";
            9:       return "R9";
            10:      return "R10";
            11:      return "R3";
            default: return "R6";
        endcase
    endfunction

    task automatic drive_ctl(input logic [2:0] ab, input logic [2:0] ba,
                             input logic [W-1:0] a, input logic [W-1:0] b);
        {ab_en_n, ab_le_n, ab_oe_n} = ab;
        {ba_en_n, ba_le_n, ba_oe_n} = ba;
        a_in = a;
        b_in = b;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1", 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        rst = 1'b0;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            drive_ctl(VECS[i].ab, VECS[i].ba, VECS[i].a, VECS[i].b);
            @(negedge clk);
            check_all(vec_tag(i), VECS[i].exp_b, VECS[i].exp_bd,
                      VECS[i].exp_a, VECS[i].exp_ad, VECS[i].exp_c);
        end

        // R10: both paths transparent and driving
        drive_ctl(3'b000, 3'b000, 8'h12, 8'h34);
        @(negedge clk);
        check_all("R10", 8'h12, 1'b1, 8'h34, 1'b1, 1'b1);

        // R8: walking one through the A-to-B path, bit n lands on bit n
        for (int k = 0; k < W; k++) begin
            drive_ctl(3'b000, 3'b111, W'(1) << k, 8'h00);
            @(negedge clk);
            check("R8", "b_out walking one", b_out, W'(1) << k);
        end

        // R1: reset in mid-run while data is flowing
        drive_ctl(3'b000, 3'b000, 8'hFF, 8'hEE);
        rst = 1'b1;
        @(negedge clk);
        check_all("R1", 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        drive_ctl(3'b111, 3'b111, 8'hFF, 8'hEE);
        @(negedge clk);
        rst = 1'b0;
        // R1: strobe high right after reset counts as no edge: word stays 0
        drive_ctl(3'b010, 3'b010, 8'hAB, 8'hCD);
        @(negedge clk);
        check_all("R1", 8'h00, 1'b1, 8'h00, 1'b1, 1'b1);

        // R5: B-to-A holds through several source changes
        for (int k = 0; k < 3; k++) begin
            drive_ctl(3'b010, 3'b010, 8'h10 + W'(k), 8'h20 + W'(k));
            @(negedge clk);
            check("R5", "a_out held", a_out, 8'h00);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule